// File: doc/BRIEF.md
# Edge-Registered Glitch-Free Clock Gate

This block passes or stops a free-running clock under a synchronous enable without ever shortening a clock pulse. The raw enable is captured by a flip-flop on the clock edge that opens the clock's idle phase. A two-input gating function then combines the registered enable with the clock. Because the registered enable can only change while the clock sits at the level the gate already forces, the output either carries a full, unmodified pulse or stays at its rest level.

A parameter picks one of two polarities. In AND polarity the output rests low and the enable is registered on the falling edge. In OR polarity the output rests high and the enable is registered on the rising edge. Any richer gating function belongs to one of these two kinds, depending on which clock phase the enable is allowed to move in. An active-low asynchronous reset clears the enable register, so the output sits at its rest level.

Top module: `edge_clock_gate`

## Requirements
- R1: With STYLE = GATE_AND (encoding 0), gclk_o copies clk_i during each high phase in which the enable register holds 1, and is 0 at all other times.
- R2: With STYLE = GATE_OR (encoding 1), gclk_o is 0 during each low phase of clk_i in which the enable register holds 1, and is 1 at all other times.
- R3: In GATE_AND, en_i is sampled on the falling edge of clk_i. A change of en_i takes effect from the first rising edge after the next falling edge. A change made during a high phase leaves the pulse in progress untouched.
- R4: In GATE_OR, en_i is sampled on the rising edge of clk_i. A change of en_i takes effect from the first falling edge after the next rising edge. A change made during a low phase leaves the low pulse in progress untouched.
- R5: Every pulse that reaches gclk_o has the same width as the matching clk_i pulse: high pulses in GATE_AND and low pulses in GATE_OR.
- R6: Outside reset, the enable register changes only while clk_i is at the rest level of the selected style: 0 for GATE_AND and 1 for GATE_OR.
- R7: Driving rst_ni low clears the enable register at once, without a clock edge, and forces gclk_o to its rest level (0 for GATE_AND, 1 for GATE_OR). After release, gclk_o stays at rest until en_i has been sampled as 1.
- R8: The number of pulses on gclk_o equals the number of sampling edges at which en_i was 1. Enabling and disabling only add or remove whole pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running input clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the enable register |
| en_i | input | 1 | Raw enable, synchronous to clk_i |
| gclk_o | output | 1 | Gated clock output |

## Verification
Both polarities run side by side from one clock and one enable. Directed steps move the enable just after the sampling edge and also inside the active phase. This shows whether a change waits a full phase and whether a pulse in progress is left whole. A stream of enable toggles at random points in both phases is then counted pulse by pulse against an independent model of the sampling edge. This separates a gate that only adds or drops whole pulses from one that splits or clips them. The output pulse widths are timed against the input half period. Reset is applied while the gate is open and while the enable is held high, to show that the output rests at once and reopens only after a fresh sample.

// File: rtl/ecg_pkg.sv
package ecg_pkg;

   // Gating polarity: AND rests low, OR rests high.
   typedef enum logic {
      GATE_AND = 1'b0,
      GATE_OR  = 1'b1
   } gate_style_e;

   // Level the gated clock holds while blocked.
   function automatic logic rest_level(gate_style_e style);
      return (style == GATE_OR) ? 1'b1 : 1'b0;
   endfunction

endpackage

// File: rtl/ecg_enable_reg.sv
module ecg_enable_reg
   import ecg_pkg::*;
#(
   parameter gate_style_e STYLE = GATE_AND
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);

   logic q_r;

   generate
      if (STYLE == GATE_AND) begin : g_fall_capture
         // Captured as the clock enters its low (idle) phase.
         always_ff @(negedge clk_i or negedge rst_ni) begin
            if (!rst_ni) q_r <= 1'b0;
            else         q_r <= d_i;
         end
      end else begin : g_rise_capture
         // Captured as the clock enters its high (idle) phase.
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) q_r <= 1'b0;
            else         q_r <= d_i;
         end
      end
   endgenerate

   assign q_o = q_r;

endmodule

// File: rtl/ecg_gate_cell.sv
module ecg_gate_cell
   import ecg_pkg::*;
#(
   parameter gate_style_e STYLE = GATE_AND
) (
   input  logic clk_i,
   input  logic en_i,
   output logic gclk_o
);

   generate
      if (STYLE == GATE_AND) begin : g_and_cell
         assign gclk_o = clk_i & en_i;
      end else begin : g_or_cell
         assign gclk_o = clk_i | ~en_i;
      end
   endgenerate

endmodule

// File: rtl/edge_clock_gate.sv
module edge_clock_gate
   import ecg_pkg::*;
#(
   parameter gate_style_e STYLE = GATE_AND
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic gclk_o
);

   generate
      if (!(STYLE inside {GATE_AND, GATE_OR})) begin : g_bad_style
         $error("edge_clock_gate: unsupported STYLE");
      end
   endgenerate

   logic en_q;

   ecg_enable_reg #(.STYLE(STYLE)) u_en_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (en_i),
      .q_o    (en_q)
   );

   ecg_gate_cell #(.STYLE(STYLE)) u_cell (
      .clk_i  (clk_i),
      .en_i   (en_q),
      .gclk_o (gclk_o)
   );

endmodule

// File: rtl/ecg_checker.sv
module ecg_checker
   import ecg_pkg::*;
#(
   parameter gate_style_e STYLE = GATE_AND
) (
   input logic clk_i,
   input logic rst_ni,
   input logic en_q,
   input logic gclk_o
);

   localparam logic REST = rest_level(STYLE);

   generate
      if (STYLE == GATE_AND) begin : g_and_props
         // Sampled at the falling edge = value through the high phase (R1, R5).
         assert_and_pass_R1: assert property (@(negedge clk_i) disable iff (!rst_ni)
            gclk_o == en_q)
            else $error("AND gate high phase does not follow enable register");
         assert_and_full_pulse_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
            en_q |-> gclk_o)
            else $error("AND gate high pulse clipped");
         // Sampled at the rising edge = value through the low phase.
         assert_and_rest_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            gclk_o == 1'b0)
            else $error("AND gate output high during clock low phase");
      end else begin : g_or_props
         assert_or_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            gclk_o == !en_q)
            else $error("OR gate low phase does not follow enable register");
         assert_or_full_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            en_q |-> !gclk_o)
            else $error("OR gate low pulse clipped");
         assert_or_rest_R2: assert property (@(negedge clk_i) disable iff (!rst_ni)
            gclk_o == 1'b1)
            else $error("OR gate output low during clock high phase");
      end
   endgenerate

   // Reset holds the output at rest (R7).
   assert_reset_rest_R7: assert property (@(posedge clk_i)
      !rst_ni |-> gclk_o == REST)
      else $error("gated clock not at rest level during reset");

   // Enable register may only move while the clock is idle (R6).
   always @(en_q) begin
      if (rst_ni) begin
         assert_en_idle_phase_R6: assert (clk_i == REST)
            else $error("enable register changed in the active clock phase");
      end
   end

endmodule

bind edge_clock_gate ecg_checker #(.STYLE(STYLE)) u_ecg_checker (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .en_q   (en_q),
   .gclk_o (gclk_o)
);

// File: tb/edge_clock_gate_tb.sv
`timescale 1ns/1ps
module edge_clock_gate_tb;
   import ecg_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic gclk_and;
   logic gclk_or;

   int n_cmp = 0;
   int n_bad = 0;

   // Independent reference of the sampling edges
   logic exp_and = 1'b0;
   logic exp_or  = 1'b0;

   int cnt_and = 0;
   int cnt_or  = 0;
   int want_and = 0;
   int want_or  = 0;

   always #4 clk = ~clk;   // 125 MHz

   edge_clock_gate #(.STYLE(GATE_AND)) u_dut (
      .clk_i (clk), .rst_ni (rst_n), .en_i (en), .gclk_o (gclk_and)
   );

   edge_clock_gate #(.STYLE(GATE_OR)) u_dut_or (
      .clk_i (clk), .rst_ni (rst_n), .en_i (en), .gclk_o (gclk_or)
   );

   always @(negedge clk or negedge rst_n)
      if (!rst_n) exp_and <= 1'b0; else exp_and <= en;
   always @(posedge clk or negedge rst_n)
      if (!rst_n) exp_or <= 1'b0; else exp_or <= en;

   always @(posedge gclk_and) cnt_and++;
   always @(negedge gclk_or)  cnt_or++;

   task automatic chk(string tag, logic act, logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
      end
   endtask

   task automatic chk_int(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
      end
   endtask

   task automatic high_mid(); @(posedge clk); #2; endtask
   task automatic low_mid();  @(negedge clk); #2; endtask

   // One full cycle compared against the reference (R1, R2)
   task automatic check_cycle();
      high_mid();
      chk("R1 and high phase", gclk_and, exp_and);
      chk("R2 or high phase", gclk_or, 1'b1);
      if (exp_and) want_and++;
      low_mid();
      chk("R1 and low phase", gclk_and, 1'b0);
      chk("R2 or low phase", gclk_or, ~exp_or);
      if (exp_or) want_or++;
   endtask

   task automatic test_reset();
      #1;
      chk("R7 and rest in reset", gclk_and, 1'b0);
      chk("R7 or rest in reset", gclk_or, 1'b1);
      en = 1'b1;
      high_mid();
      chk("R7 and rest in reset high", gclk_and, 1'b0);
      low_mid();
      chk("R7 or rest in reset low", gclk_or, 1'b1);
      en = 1'b0;
      @(negedge clk); #1 rst_n = 1'b1;
      repeat (2) check_cycle();
   endtask

   task automatic test_and_sampling();
      @(negedge clk); #1 en = 1'b1;
      high_mid();
      chk("R3 and waits for falling edge", gclk_and, 1'b0);
      high_mid();
      chk("R3 and opens after falling edge", gclk_and, 1'b1);
      en = 1'b0;            // mid high phase
      #1;
      chk("R3 and pulse kept after high-phase drop", gclk_and, 1'b1);
      high_mid();
      chk("R3 and closed next cycle", gclk_and, 1'b0);
   endtask

   task automatic test_or_sampling();
      @(posedge clk); #1 en = 1'b1;
      low_mid();
      chk("R4 or waits for rising edge", gclk_or, 1'b1);
      low_mid();
      chk("R4 or opens after rising edge", gclk_or, 1'b0);
      en = 1'b0;            // mid low phase
      #1;
      chk("R4 or low pulse kept after drop", gclk_or, 1'b0);
      low_mid();
      chk("R4 or closed next cycle", gclk_or, 1'b1);
   endtask

   task automatic test_pulse_width();
      realtime t0;
      realtime w;
      en = 1'b1;
      repeat (3) @(posedge clk);
      @(posedge gclk_and); t0 = $realtime;
      @(negedge gclk_and); w = $realtime - t0;
      chk("R5 and high pulse width", (w > 3.999 && w < 4.001), 1'b1);
      @(negedge gclk_or); t0 = $realtime;
      @(posedge gclk_or); w = $realtime - t0;
      chk("R5 or low pulse width", (w > 3.999 && w < 4.001), 1'b1);
      en = 1'b0;
      repeat (3) @(posedge clk);
   endtask

   task automatic test_hold_off();
      en = 1'b0;
      repeat (2) @(posedge clk);
      low_mid();
      cnt_and = 0; cnt_or = 0;
      repeat (10) check_cycle();
      chk_int("R8 and no pulses while off", cnt_and, 0);
      chk_int("R8 or no pulses while off", cnt_or, 0);
   endtask

   task automatic test_random_toggle();
      low_mid();
      cnt_and = 0; cnt_or = 0; want_and = 0; want_or = 0;
      fork
         begin
            for (int i = 0; i < 400; i++) begin
               @(clk);
               #($urandom_range(3, 1));
               en = 1'($urandom_range(1, 0));
            end
         end
         begin
            for (int i = 0; i < 200; i++) check_cycle();
         end
      join
      chk_int("R8 and pulse count", cnt_and, want_and);
      chk_int("R8 or pulse count", cnt_or, want_or);
      en = 1'b0;
   endtask

   task automatic test_reset_midstream();
      en = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); #1 rst_n = 1'b0;
      #1;
      chk("R7 and rest at once", gclk_and, 1'b0);
      chk("R7 or rest at once", gclk_or, 1'b1);
      high_mid();
      chk("R7 and held while reset", gclk_and, 1'b0);
      low_mid();
      chk("R7 or held while reset", gclk_or, 1'b1);
      @(negedge clk); #1 rst_n = 1'b1;
      high_mid();
      chk("R7 and stays at rest before sample", gclk_and, 1'b0);
      low_mid();
      chk("R7 or reopens after rising sample", gclk_or, 1'b0);
      high_mid();
      chk("R7 and reopens after falling sample", gclk_and, 1'b1);
      en = 1'b0;
      repeat (3) @(posedge clk);
   endtask

   initial begin
      test_reset();
      test_and_sampling();
      test_or_sampling();
      test_pulse_width();
      test_hold_off();
      test_random_toggle();
      test_reset_midstream();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule